// File: doc/BRIEF.md
# Request/Reply Network Endpoint with Reserved Input Slots

This block connects one node to a network that carries two transaction classes: requests and the replies they cause. Each class has its own input queue and its own output queue, so a reply never waits behind a request in either direction. The request input queue is sized to hold K outstanding transactions from each of the other P-1 nodes. The reply input queue holds K entries.

The endpoint services arriving requests by itself with a fetch-and-add on an internal accumulator. It takes a request from the request input queue only when the reply output queue has room for the answer. If a request arrives while every request slot is taken, the endpoint does not stall the network. It refuses the request with a negative acknowledgement (NACK) that travels back on the reply class and carries the refused payload, so the source can retry. Local requests leave under per-destination credits. A credit is spent when a request is issued and returned when the reply or NACK for it arrives.

All four data paths are valid/ready streams, and a transfer happens on a rising edge where valid and ready are both high. A producer holds valid and its fields until the transfer. `net_in_ready` depends on `net_in_kind`, because each class is judged by its own reserved space. `loc_req_ready` depends on `loc_req_dst`. While `net_out_valid` is stalled it stays high, but a reply that becomes ready takes the port in place of a waiting request. Kind codes on the network are 2'b00 for a request, 2'b01 for a reply and 2'b10 for a NACK. Any other code is handled as a reply.

Top module: `txn_endpoint`

## Requirements
- R1: After reset, `net_out_valid` and `loc_dlv_valid` are low, `net_in_ready` is high for both classes, and `loc_req_ready` is high for every peer destination other than NODE_ID.
- R2: An arriving request (kind 2'b00) is accepted whenever fewer than K*(P-1) requests are held. This holds even when the reply input queue is full and local delivery is stalled.
- R3: An arriving reply or NACK is accepted while fewer than K reply entries are held and is refused (ready low) when K are held. Entries reach the local delivery port in arrival order with their source, their data and `loc_dlv_nack` = 1 for kind 2'b10.
- R4: A request that arrives while all request slots are full is accepted if the reply output queue has room. It is answered with a NACK (kind 2'b10) to its source that carries the same data. `net_in_ready` for a request is low only when both queues are full.
- R5: Each serviced request produces exactly one reply (kind 2'b01) to its source. The reply data is the accumulator value before the request. The accumulator then adds the request data, modulo 2^DATA_W, and starts from zero at reset. Requests are serviced in arrival order.
- R6: A request is serviced only when the reply output queue has a free entry. When a NACK and a service want the same free entry in the same cycle, the NACK takes it.
- R7: On `net_out`, a held reply or NACK is always presented before any held request. Within a class, entries leave in the order they were queued. A stalled `net_out_valid` stays high.
- R8: `loc_req_ready` is high only when the credit count for `loc_req_dst` is nonzero, `loc_req_dst` differs from NODE_ID, and the request output queue is not full. Each issue spends one credit. Each peer starts with K credits.
- R9: Accepting a reply or NACK from a peer returns one credit to that peer.
- R10: An issued local request leaves on `net_out` with kind 2'b00, `net_out_dst` equal to its destination and its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| net_in_valid | input | 1 | Arriving transaction valid |
| net_in_ready | output | 1 | Arriving transaction accepted |
| net_in_kind | input | 2 | 00 request, 01 reply, 10 NACK |
| net_in_src | input | ID_W | Node that sent the transaction |
| net_in_data | input | DATA_W | Transaction payload |
| net_out_valid | output | 1 | Departing transaction valid |
| net_out_ready | input | 1 | Network takes the departing transaction |
| net_out_kind | output | 2 | 00 request, 01 reply, 10 NACK |
| net_out_dst | output | ID_W | Destination node |
| net_out_data | output | DATA_W | Departing payload |
| loc_req_valid | input | 1 | Local request valid |
| loc_req_ready | output | 1 | Local request accepted |
| loc_req_dst | input | ID_W | Destination of the local request |
| loc_req_data | input | DATA_W | Local request payload |
| loc_dlv_valid | output | 1 | Reply or NACK ready for the local side |
| loc_dlv_ready | input | 1 | Local side takes the delivery |
| loc_dlv_nack | output | 1 | Delivery is a NACK of an earlier request |
| loc_dlv_src | output | ID_W | Node that answered |
| loc_dlv_data | output | DATA_W | Reply data, or the refused payload |

## Verification
The reply output queue has one write port, and two functions can claim its single free entry in the same cycle: the NACK for a refused arrival and the service of a queued request. The bench blocks the network output until the request queue and the reply output queue are both full, and presents one more request, which must see ready low. It then pulses `net_out_ready` for a single cycle while that request stays presented. The request must be accepted in the very next cycle. The drained output stream must show the NACK directly after the reply that was already queued, ahead of the replies to the waiting requests. A second contention, a reply and a request both ready for `net_out`, is judged by the order of the drained stream.

// File: rtl/txn_ep_pkg.sv
package txn_ep_pkg;

  typedef enum logic [1:0] {
    KIND_REQ  = 2'b00,
    KIND_REP  = 2'b01,
    KIND_NACK = 2'b10
  } kind_e;

endpackage

// File: rtl/txn_fifo.sv
module txn_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  // Queue writes must find room (R2, R3, R4 sizing)
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // Service and delivery only take held entries (R6)
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/txn_credit_bank.sv
module txn_credit_bank #(
  parameter int NODES = 4,
  parameter int K     = 2,
  parameter int ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [ID_W-1:0]  take_id,
  input  logic             give,
  input  logic [ID_W-1:0]  give_id,
  output logic [NODES-1:0] avail
);
  localparam int CW = $clog2(K + 1);

  for (genvar n = 0; n < NODES; n++) begin : g_peer
    logic [CW-1:0] cnt;
    logic          inc, dec;

    assign inc = give && (give_id == ID_W'(n));
    assign dec = take && (take_id == ID_W'(n));
    assign avail[n] = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= CW'(K);
      else if (inc && !dec)   cnt <= cnt + 1'b1;
      else if (dec && !inc)   cnt <= cnt - 1'b1;
    end

    // No issue without a credit
    assert_credit_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt != '0));
    // A returned credit never lifts the count above K
    assert_credit_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |-> (cnt < CW'(K)));
  end

endmodule

// File: rtl/txn_out_arb.sv
module txn_out_arb (
  input  logic hi_valid,
  input  logic lo_valid,
  input  logic out_ready,
  output logic out_valid,
  output logic sel_hi,
  output logic hi_pop,
  output logic lo_pop
);
  assign sel_hi    = hi_valid;
  assign out_valid = hi_valid || lo_valid;
  assign hi_pop    = hi_valid && out_ready;
  assign lo_pop    = !hi_valid && lo_valid && out_ready;
endmodule

// File: rtl/txn_endpoint.sv
module txn_endpoint
  import txn_ep_pkg::*;
#(
  parameter int NODES     = 4,
  parameter int K         = 2,
  parameter int NODE_ID   = 0,
  parameter int DATA_W    = 8,
  parameter int OUT_DEPTH = 2,
  localparam int ID_W     = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_in_valid,
  output logic              net_in_ready,
  input  logic [1:0]        net_in_kind,
  input  logic [ID_W-1:0]   net_in_src,
  input  logic [DATA_W-1:0] net_in_data,
  output logic              net_out_valid,
  input  logic              net_out_ready,
  output logic [1:0]        net_out_kind,
  output logic [ID_W-1:0]   net_out_dst,
  output logic [DATA_W-1:0] net_out_data,
  input  logic              loc_req_valid,
  output logic              loc_req_ready,
  input  logic [ID_W-1:0]   loc_req_dst,
  input  logic [DATA_W-1:0] loc_req_data,
  output logic              loc_dlv_valid,
  input  logic              loc_dlv_ready,
  output logic              loc_dlv_nack,
  output logic [ID_W-1:0]   loc_dlv_src,
  output logic [DATA_W-1:0] loc_dlv_data
);
  localparam int REQ_SLOTS = K * (NODES - 1);
  localparam int REP_SLOTS = K;
  localparam logic [ID_W:0] NODES_L = (ID_W + 1)'(NODES);

  typedef struct packed {
    logic [ID_W-1:0]   peer;
    logic [DATA_W-1:0] data;
  } req_ent_t;

  typedef struct packed {
    logic              nack;
    logic [ID_W-1:0]   peer;
    logic [DATA_W-1:0] data;
  } rep_ent_t;

  // Arrival classification
  logic in_is_req;
  assign in_is_req = (net_in_kind == KIND_REQ);

  logic     reqin_full, reqin_empty, reqin_push, serve;
  req_ent_t reqin_din, reqin_head;
  logic     repin_full, repin_empty, repin_push, dlv_pop;
  rep_ent_t repin_din, repin_head;
  logic     reqout_full, reqout_empty, issue, reqout_pop;
  req_ent_t reqout_din, reqout_head;
  logic     repout_full, repout_empty, repout_push, repout_pop;
  rep_ent_t repout_din, repout_head;
  logic     nack_go;

  // Input side: each class judged by its own reserved space
  assign reqin_push = net_in_valid && in_is_req && !reqin_full;
  assign nack_go    = net_in_valid && in_is_req && reqin_full && !repout_full;
  assign repin_push = net_in_valid && !in_is_req && !repin_full;
  assign net_in_ready = in_is_req ? (!reqin_full || !repout_full) : !repin_full;

  assign reqin_din = '{peer: net_in_src, data: net_in_data};
  assign repin_din = '{nack: (net_in_kind == KIND_NACK), peer: net_in_src,
                       data: net_in_data};

  txn_fifo #(.W($bits(req_ent_t)), .DEPTH(REQ_SLOTS)) u_reqin (
    .clk(clk), .rst_n(rst_n), .push(reqin_push), .din(reqin_din),
    .pop(serve), .dout(reqin_head), .full(reqin_full), .empty(reqin_empty));

  txn_fifo #(.W($bits(rep_ent_t)), .DEPTH(REP_SLOTS)) u_repin (
    .clk(clk), .rst_n(rst_n), .push(repin_push), .din(repin_din),
    .pop(dlv_pop), .dout(repin_head), .full(repin_full), .empty(repin_empty));

  // Local delivery
  assign loc_dlv_valid = !repin_empty;
  assign dlv_pop       = loc_dlv_valid && loc_dlv_ready;
  assign loc_dlv_nack  = repin_head.nack;
  assign loc_dlv_src   = repin_head.peer;
  assign loc_dlv_data  = repin_head.data;

  // Request service: fetch-and-add, gated by reply output room, NACK first
  logic [DATA_W-1:0] acc;
  assign serve       = !reqin_empty && !repout_full && !nack_go;
  assign repout_push = nack_go || serve;
  assign repout_din  = nack_go
                     ? '{nack: 1'b1, peer: net_in_src, data: net_in_data}
                     : '{nack: 1'b0, peer: reqin_head.peer, data: acc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (serve) acc <= acc + reqin_head.data;
  end

  txn_fifo #(.W($bits(rep_ent_t)), .DEPTH(OUT_DEPTH)) u_repout (
    .clk(clk), .rst_n(rst_n), .push(repout_push), .din(repout_din),
    .pop(repout_pop), .dout(repout_head), .full(repout_full),
    .empty(repout_empty));

  // Local issue under per-destination credit
  logic [NODES-1:0] credit_ok;
  logic             dst_ok;
  assign dst_ok = ({1'b0, loc_req_dst} < NODES_L) &&
                  (loc_req_dst != ID_W'(NODE_ID));
  assign loc_req_ready = dst_ok && credit_ok[loc_req_dst] && !reqout_full;
  assign issue         = loc_req_valid && loc_req_ready;
  assign reqout_din    = '{peer: loc_req_dst, data: loc_req_data};

  txn_credit_bank #(.NODES(NODES), .K(K), .ID_W(ID_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .take(issue), .take_id(loc_req_dst),
    .give(repin_push), .give_id(net_in_src), .avail(credit_ok));

  txn_fifo #(.W($bits(req_ent_t)), .DEPTH(OUT_DEPTH)) u_reqout (
    .clk(clk), .rst_n(rst_n), .push(issue), .din(reqout_din),
    .pop(reqout_pop), .dout(reqout_head), .full(reqout_full),
    .empty(reqout_empty));

  // Network output: reply class strictly first
  logic sel_rep;
  txn_out_arb u_arb (
    .hi_valid(!repout_empty), .lo_valid(!reqout_empty),
    .out_ready(net_out_ready), .out_valid(net_out_valid),
    .sel_hi(sel_rep), .hi_pop(repout_pop), .lo_pop(reqout_pop));

  assign net_out_kind = !sel_rep ? KIND_REQ
                      : (repout_head.nack ? KIND_NACK : KIND_REP);
  assign net_out_dst  = sel_rep ? repout_head.peer : reqout_head.peer;
  assign net_out_data = sel_rep ? repout_head.data : reqout_head.data;

  // A request with free reserved space is never refused
  assert_sink_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (net_in_valid && in_is_req && !reqin_full) |-> net_in_ready);
  // A NACK is only produced for a request that found its slots full
  assert_nack_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (repout_push && repout_din.nack) |-> (reqin_full && !reqin_push));
  // A request goes out only while no reply is held
  assert_reply_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (net_out_valid && net_out_kind == KIND_REQ) |-> repout_empty);
  // A stalled output keeps valid high
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (net_out_valid && !net_out_ready) |=> net_out_valid);

endmodule

// File: tb/test_txn_endpoint.sv
`timescale 1ns/1ps
module test_txn_endpoint;
  localparam int NODES = 4, K = 2, DW = 8, IDW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic net_in_valid = 0, net_out_ready = 0, loc_req_valid = 0, loc_dlv_ready = 1;
  logic [1:0] net_in_kind = 0;
  logic [IDW-1:0] net_in_src = 0, loc_req_dst = 1;
  logic [DW-1:0] net_in_data = 0, loc_req_data = 0;
  logic net_in_ready, net_out_valid, loc_req_ready, loc_dlv_valid, loc_dlv_nack;
  logic [1:0] net_out_kind;
  logic [IDW-1:0] net_out_dst, loc_dlv_src;
  logic [DW-1:0] net_out_data, loc_dlv_data;

  always #2.5 clk = ~clk;

  txn_endpoint i_txn_endpoint (
    .clk(clk), .rst_n(rst_n),
    .net_in_valid(net_in_valid), .net_in_ready(net_in_ready),
    .net_in_kind(net_in_kind), .net_in_src(net_in_src), .net_in_data(net_in_data),
    .net_out_valid(net_out_valid), .net_out_ready(net_out_ready),
    .net_out_kind(net_out_kind), .net_out_dst(net_out_dst),
    .net_out_data(net_out_data),
    .loc_req_valid(loc_req_valid), .loc_req_ready(loc_req_ready),
    .loc_req_dst(loc_req_dst), .loc_req_data(loc_req_data),
    .loc_dlv_valid(loc_dlv_valid), .loc_dlv_ready(loc_dlv_ready),
    .loc_dlv_nack(loc_dlv_nack), .loc_dlv_src(loc_dlv_src),
    .loc_dlv_data(loc_dlv_data));

  int n_cmp = 0, n_bad = 0, acc_m = 0;
  bit finished = 0;

  int ok_kind [256], ok_dst [256], ok_data [256];
  int on = 0;
  int dl_nack [256], dl_src [256], dl_data [256];
  int dn = 0;

  // Record completed transfers mid-cycle; inputs change just after posedge
  always @(negedge clk) begin
    if (rst_n && net_out_valid && net_out_ready) begin
      ok_kind[on] = net_out_kind; ok_dst[on] = net_out_dst;
      ok_data[on] = net_out_data; on++;
    end
    if (rst_n && loc_dlv_valid && loc_dlv_ready) begin
      dl_nack[dn] = loc_dlv_nack; dl_src[dn] = loc_dlv_src;
      dl_data[dn] = loc_dlv_data; dn++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic net_send(int kind, int src, int data);
    bit took;
    net_in_valid = 1; net_in_kind = 2'(kind);
    net_in_src = IDW'(src); net_in_data = DW'(data);
    took = 0;
    while (!took) begin
      @(negedge clk); took = net_in_ready;
      tick();
    end
    net_in_valid = 0;
  endtask

  task automatic loc_issue(int dst, int data);
    bit took;
    loc_req_valid = 1; loc_req_dst = IDW'(dst); loc_req_data = DW'(data);
    took = 0;
    while (!took) begin
      @(negedge clk); took = loc_req_ready;
      tick();
    end
    loc_req_valid = 0;
  endtask

  task automatic wait_out(int n);
    while (on < n) tick();
  endtask

  task automatic ready_for(int dst, int exp, string tag);
    loc_req_dst = IDW'(dst);
    @(negedge clk);
    chk(tag, int'(loc_req_ready), exp);
    tick();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 net_out_valid", int'(net_out_valid), 0);
    chk("R1 loc_dlv_valid", int'(loc_dlv_valid), 0);
    chk("R1 net_in_ready req", int'(net_in_ready), 1);
    net_in_kind = 2'b01;
    #0.5 chk("R1 net_in_ready rep", int'(net_in_ready), 1);
    net_in_kind = 2'b00;
    tick();
    for (int d = 1; d < NODES; d++) ready_for(d, 1, "R1 loc_req_ready peer");
  endtask

  task automatic t_issue_credit();
    int b;
    b = on;
    net_out_ready = 0;
    loc_issue(1, 8'h21);
    loc_issue(1, 8'h22);
    ready_for(1, 0, "R8 no credit and queue full");
    ready_for(2, 0, "R8 request queue full");
    net_out_ready = 1;
    wait_out(b + 2);
    chk("R10 kind 0", ok_kind[b], 0);
    chk("R10 dst", ok_dst[b], 1);
    chk("R10 data 1", ok_data[b], 'h21);
    chk("R10 data 2", ok_data[b+1], 'h22);
    ready_for(1, 0, "R8 credits spent");
    ready_for(2, 1, "R8 other peer");
    ready_for(0, 0, "R8 self destination");
    b = dn;
    net_send(1, 1, 8'h33);
    repeat (2) tick();
    ready_for(1, 1, "R9 credit returned");
    chk("R3 delivered count", dn - b, 1);
    chk("R3 delivered src", dl_src[b], 1);
    chk("R3 delivered data", dl_data[b], 'h33);
    chk("R3 delivered nack flag", dl_nack[b], 0);
  endtask

  task automatic t_service();
    int b;
    b = on;
    net_out_ready = 0;
    net_send(0, 1, 5);
    net_send(0, 2, 7);
    net_send(0, 3, 9);
    repeat (3) tick();
    chk("R6 held replies only", on - b, 0);
    net_out_ready = 1;
    wait_out(b + 3);
    for (int i = 0; i < 3; i++) begin
      chk("R5 reply kind", ok_kind[b+i], 1);
      chk("R5 reply dst", ok_dst[b+i], i + 1);
      chk("R5 reply data", ok_data[b+i], acc_m);
      acc_m = (acc_m + 5 + 2 * i) % 256;
    end
  endtask

  task automatic t_nack();
    int b, a;
    b = on;
    net_out_ready = 0;
    for (int i = 0; i < 8; i++) net_send(0, 1 + i % 3, 10 + i);
    repeat (3) tick();
    net_in_valid = 1; net_in_kind = 2'b00; net_in_src = 3; net_in_data = 8'h55;
    @(negedge clk);
    chk("R4 refused with both queues full", int'(net_in_ready), 0);
    tick();
    net_out_ready = 1;
    @(negedge clk);
    chk("R4 still refused during pop cycle", int'(net_in_ready), 0);
    tick();
    net_out_ready = 0;
    @(negedge clk);
    chk("R4 accepted once reply room frees", int'(net_in_ready), 1);
    tick();
    net_in_valid = 0;
    net_out_ready = 1;
    wait_out(b + 9);
    a = acc_m;
    for (int i = 0; i < 9; i++) begin
      if (i == 2) begin
        chk("R6 NACK ahead of queued service", ok_kind[b+i], 2);
        chk("R4 NACK dst", ok_dst[b+i], 3);
        chk("R4 NACK data", ok_data[b+i], 'h55);
      end else begin
        int r;
        r = (i < 2) ? i : i - 1;
        chk("R5 reply kind", ok_kind[b+i], 1);
        chk("R5 reply dst", ok_dst[b+i], 1 + r % 3);
        chk("R5 reply data", ok_data[b+i], a);
        a = (a + 10 + r) % 256;
      end
    end
    acc_m = a;
  endtask

  task automatic t_priority();
    int b, d;
    b = on;
    net_out_ready = 0;
    loc_issue(2, 8'hA1);
    loc_issue(3, 8'hA2);
    net_send(0, 1, 3);
    repeat (2) tick();
    net_out_ready = 1;
    wait_out(b + 3);
    chk("R7 reply first kind", ok_kind[b], 1);
    chk("R7 reply first data", ok_data[b], acc_m);
    acc_m = (acc_m + 3) % 256;
    chk("R7 request second", ok_dst[b+1], 2);
    chk("R7 request order", ok_dst[b+2], 3);
    chk("R10 request data", ok_data[b+2], 'hA2);
    d = dn;
    net_send(2, 2, 8'h66);
    net_send(1, 3, 8'h77);
    repeat (2) tick();
    chk("R3 NACK flag", dl_nack[d], 1);
    chk("R3 NACK data", dl_data[d], 'h66);
    chk("R3 reply after NACK", dl_src[d+1], 3);
    chk("R3 reply flag", dl_nack[d+1], 0);
    ready_for(2, 1, "R9 credit returned by NACK");
  endtask

  task automatic t_backpressure();
    int b, d;
    net_out_ready = 1;
    b = on;
    loc_issue(1, 1); loc_issue(2, 2); loc_issue(3, 3);
    wait_out(b + 3);
    loc_dlv_ready = 0;
    d = dn;
    net_send(1, 1, 8'h11);
    net_send(1, 2, 8'h22);
    b = on;
    net_send(0, 2, 4);
    wait_out(b + 1);
    chk("R2 request served while replies blocked", ok_data[b], acc_m);
    acc_m = (acc_m + 4) % 256;
    net_in_valid = 1; net_in_kind = 2'b01; net_in_src = 3; net_in_data = 8'h33;
    @(negedge clk);
    chk("R3 reply refused when full", int'(net_in_ready), 0);
    tick();
    loc_dlv_ready = 1;
    net_send(1, 3, 8'h33);
    repeat (3) tick();
    chk("R3 delivery count", dn - d, 3);
    chk("R3 order 1", dl_data[d], 'h11);
    chk("R3 order 2", dl_data[d+1], 'h22);
    chk("R3 order 3", dl_data[d+2], 'h33);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_issue_credit();
    t_service();
    t_nack();
    t_priority();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule